// File: doc/BRIEF.md
# Frame-Aware Byte FIFO with Ready Threshold

This block is a byte-wide synchronous FIFO that sits between an image output stream and a host reader. Image bytes come in with a valid strobe. The host pulls them out one at a time with a read strobe, and each byte appears on the output register in the cycle after that strobe. A ready flag tells the host that enough bytes have built up to be worth a burst of reads.

The ready flag compares the stored byte count against an effective threshold. While a frame is active, that threshold comes from a programmable register value. In the gap between frames it drops to one, so the tail of a frame is always handed to the host. A start-of-frame pulse empties the FIFO in a single cycle. Because that flush throws bytes away, a flush that finds bytes still stored raises a one-cycle error pulse. A write that arrives while the FIFO is full also raises the error pulse.

Top module: `frame_byte_fifo`

## Requirements
- R1: While `frame_act` is 1 and `thresh` is nonzero, `ready` is 1 exactly when `level` >= `thresh`. `ready` is a combinational function of the current level, `frame_act` and `thresh`.
- R2: While `frame_act` is 0, `ready` is 1 exactly when `level` >= 1, whatever the value of `thresh`.
- R3: A `thresh` value of 0 acts as 1, so `ready` is never 1 while the FIFO is empty.
- R4: Bytes leave in the order they were accepted. A read strobe on a non-empty FIFO places the oldest byte on `rd_data` after the next rising clock edge and lowers `level` by one.
- R5: A write strobe while `full` is 1 (and `sof` is 0) is dropped, leaving the stored bytes unchanged. It raises `err` for exactly the one cycle after that edge.
- R6: A `sof` pulse empties the FIFO at the next edge, and a read strobe in the same cycle is ignored. If `wr_valid` is also 1 in that cycle, its byte is stored as the first byte of the new frame and `level` becomes 1; otherwise `level` becomes 0.
- R7: A `sof` pulse while `level` is nonzero raises `err` for one cycle after the edge. A `sof` pulse on an empty FIFO leaves `err` at 0.
- R8: A read and a write in the same cycle, with the FIFO neither full nor empty, leave `level` unchanged.
- R9: A read strobe on an empty FIFO leaves `rd_data` holding its last value and does not change `level`.
- R10: While `frame_act` stays 1 and `thresh` holds steady, `ready` falls only in the cycle after a read strobe or a `sof` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | DATA_W | Incoming image byte |
| rd_req | input | 1 | Host read strobe |
| frame_act | input | 1 | High while a frame is active |
| sof | input | 1 | Start-of-frame pulse, flushes the FIFO |
| thresh | input | $clog2(DEPTH+1) | Programmed ready threshold used during a frame |
| rd_data | output | DATA_W | Registered output byte |
| ready | output | 1 | Level >= effective threshold |
| level | output | $clog2(DEPTH+1) | Number of bytes stored |
| full | output | 1 | Level equals DEPTH |
| empty | output | 1 | Level equals zero |
| err | output | 1 | One-cycle pulse on an overflow or on a flush that discards bytes |

## Verification
The bench builds the block with DEPTH = 6. This depth is not a power of two, so the pointer variant that wraps explicitly at the last slot is the one in use, and each pointer wraps several times over a run. A depth this small lets random traffic fill the FIFO often, which exercises overflow, simultaneous read and write at both boundaries, and start-of-frame flushes of a full buffer. The 3-bit threshold can hold 0, values inside the depth and a value of 7, which lies above the depth and can never be reached.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

   // Accepted operation in a non-flush cycle
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_WR   = 2'b01,
      OP_RD   = 2'b10,
      OP_RW   = 2'b11
   } fifo_op_e;

   function automatic fifo_op_e make_op(input logic wr_acc, input logic rd_acc);
      return fifo_op_e'({rd_acc, wr_acc});
   endfunction

endpackage

// File: rtl/fbf_ptr_ctrl.sv
module fbf_ptr_ctrl
   import fbf_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic             rd_req,
   input  logic             flush,
   output logic             wr_en,
   output logic             rd_en,
   output logic [PTR_W-1:0] wr_addr,
   output logic [PTR_W-1:0] rd_addr,
   output logic [CNT_W-1:0] level,
   output logic             full,
   output logic             empty
);

   localparam bit IS_POW2 = ((1 << PTR_W) == DEPTH);

   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic [PTR_W-1:0] wr_ptr_inc, rd_ptr_inc;
   logic [CNT_W-1:0] level_q;
   fifo_op_e         op;

   assign full  = (level_q == CNT_W'(DEPTH));
   assign empty = (level_q == '0);

   // During a flush the write goes to slot 0 whatever the FIFO held
   assign wr_en   = wr_req && (flush || !full);
   assign rd_en   = rd_req && !empty && !flush;
   assign wr_addr = flush ? '0 : wr_ptr_q;
   assign rd_addr = rd_ptr_q;
   assign level   = level_q;
   assign op      = make_op(wr_en, rd_en);

   generate
      if (IS_POW2) begin : g_wrap_pow2
         assign wr_ptr_inc = wr_ptr_q + 1'b1;
         assign rd_ptr_inc = rd_ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_ptr_inc = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
         assign rd_ptr_inc = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level_q  <= '0;
      end else if (flush) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= wr_en ? PTR_W'(1) : '0;
         level_q  <= wr_en ? CNT_W'(1) : '0;
      end else begin
         case (op)
            OP_WR: begin
               wr_ptr_q <= wr_ptr_inc;
               level_q  <= level_q + 1'b1;
            end
            OP_RD: begin
               rd_ptr_q <= rd_ptr_inc;
               level_q  <= level_q - 1'b1;
            end
            OP_RW: begin
               wr_ptr_q <= wr_ptr_inc;
               rd_ptr_q <= rd_ptr_inc;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/fbf_store.sv
module fbf_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [PTR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   // Output register holds its value unless a real read happens
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_en) begin
         rd_q <= mem_q[rd_addr];
      end
   end

   assign rd_data = rd_q;

endmodule

// File: rtl/fbf_ready.sv
module fbf_ready #(
   parameter int CNT_W = 5
) (
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-1:0] thresh,
   input  logic             frame_act,
   output logic             ready
);

   logic [CNT_W-1:0] eff_thr;

   always_comb begin
      if (!frame_act || (thresh == '0)) begin
         eff_thr = CNT_W'(1);
      end else begin
         eff_thr = thresh;
      end
   end

   assign ready = (level >= eff_thr);

endmodule

// File: rtl/frame_byte_fifo.sv
module frame_byte_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   input  logic              frame_act,
   input  logic              sof,
   input  logic [CNT_W-1:0]  thresh,
   output logic [DATA_W-1:0] rd_data,
   output logic              ready,
   output logic [CNT_W-1:0]  level,
   output logic              full,
   output logic              empty,
   output logic              err
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("frame_byte_fifo: DATA_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("frame_byte_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic             wr_en, rd_en;
   logic [PTR_W-1:0] wr_addr, rd_addr;
   logic             err_q;

   fbf_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (wr_valid),
      .rd_req  (rd_req),
      .flush   (sof),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .wr_addr (wr_addr),
      .rd_addr (rd_addr),
      .level   (level),
      .full    (full),
      .empty   (empty)
   );

   fbf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   fbf_ready #(.CNT_W(CNT_W)) ready_i (
      .level     (level),
      .thresh    (thresh),
      .frame_act (frame_act),
      .ready     (ready)
   );

   // Error pulse: overflow outside a flush, or a flush that discards bytes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else begin
         err_q <= sof ? !empty : (wr_valid && full);
      end
   end

   assign err = err_q;

endmodule

// File: rtl/fbf_checker.sv
module fbf_checker #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              rd_req,
   input logic              frame_act,
   input logic              sof,
   input logic [CNT_W-1:0]  thresh,
   input logic [DATA_W-1:0] rd_data,
   input logic              ready,
   input logic [CNT_W-1:0]  level,
   input logic              full,
   input logic              empty,
   input logic              err
);

   // R3
   empty_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !ready);

   // R2
   gap_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_act && !empty) |-> ready);

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && full && !sof) |=> (err && level <= CNT_W'(DEPTH)));

   // R5
   overflow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && full && !sof && !rd_req) |=> (full && $stable(level)));

   // R6
   flush_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> (level == CNT_W'($past(wr_valid))));

   // R7
   flush_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> (err == !$past(empty)));

   // R8
   rw_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && rd_req && !full && !empty && !sof) |=> $stable(level));

   // R9
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && empty && !sof) |=> ($stable(rd_data) && level == CNT_W'($past(wr_valid))));

   // R10
   ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ready) && frame_act && $past(frame_act) && $stable(thresh))
         |-> ($past(rd_req) || $past(sof)));

endmodule

bind frame_byte_fifo fbf_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_valid  (wr_valid),
   .rd_req    (rd_req),
   .frame_act (frame_act),
   .sof       (sof),
   .thresh    (thresh),
   .rd_data   (rd_data),
   .ready     (ready),
   .level     (level),
   .full      (full),
   .empty     (empty),
   .err       (err)
);

// File: tb/frame_byte_fifo_tb.sv
module frame_byte_fifo_tb_top;

   localparam int DW    = 8;
   localparam int DEPTH = 6;
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_valid, rd_req, frame_act, sof;
   logic [DW-1:0] wr_data;
   logic [CW-1:0] thresh;
   logic [DW-1:0] rd_data;
   logic          ready, full, empty, err;
   logic [CW-1:0] level;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [DW-1:0] q[$];
   logic [DW-1:0] m_rd  = '0;
   bit            m_err = 1'b0;

   always #10 clk = ~clk;

   frame_byte_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .rd_req(rd_req), .frame_act(frame_act), .sof(sof), .thresh(thresh),
      .rd_data(rd_data), .ready(ready), .level(level), .full(full),
      .empty(empty), .err(err)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_ready(bit fa, int th, int n);
      int eff;
      eff = (!fa || th == 0) ? 1 : th;
      return (n >= eff) ? 1 : 0;
   endfunction

   function automatic string ready_req(bit fa, int th);
      if (!fa) return "R2";
      if (th == 0) return "R3";
      return "R1";
   endfunction

   task automatic step(bit wv, logic [DW-1:0] wd, bit rd, bit fa, bit sf, logic [CW-1:0] th);
      bit    was_empty, was_full;
      string lreq;
      wr_valid  = wv;
      wr_data   = wd;
      rd_req    = rd;
      frame_act = fa;
      sof       = sf;
      thresh    = th;
      #1;
      chk(ready_req(fa, int'(th)), "ready", int'(ready), exp_ready(fa, int'(th), q.size()));
      was_empty = (q.size() == 0);
      was_full  = (q.size() == DEPTH);
      @(posedge clk);
      if (sf) begin
         m_err = !was_empty;
         q.delete();
         if (wv) q.push_back(wd);
      end else begin
         m_err = wv && was_full;
         if (rd && !was_empty) m_rd = q.pop_front();
         if (wv && !was_full) q.push_back(wd);
      end
      @(negedge clk);
      lreq = sf ? "R6" : ((wv && rd && !was_empty && !was_full) ? "R8" : "R4");
      chk((rd && was_empty && !sf) ? "R9" : "R4", "rd_data", int'(rd_data), int'(m_rd));
      chk(lreq, "level", int'(level), q.size());
      chk(sf ? "R7" : "R5", "err", int'(err), int'(m_err));
      chk("R5", "full", int'(full), int'(q.size() == DEPTH));
      chk("R4", "empty", int'(empty), int'(q.size() == 0));
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; wr_valid = 0; rd_req = 0; frame_act = 0; sof = 0;
      wr_data = '0; thresh = '0;
      repeat (3) @(negedge clk);
      chk("R4", "reset level", int'(level), 0);
      chk("R4", "reset empty", int'(empty), 1);
      chk("R3", "reset ready", int'(ready), 0);
      chk("R7", "reset err", int'(err), 0);
      chk("R4", "reset rd_data", int'(rd_data), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: single byte in the gap is ready; R4 read back; R9 empty read
      step(1, 8'h11, 0, 0, 0, 3'd5);
      step(0, 8'h00, 0, 0, 0, 3'd5);
      step(0, 8'h00, 1, 0, 0, 3'd5);
      step(0, 8'h00, 1, 0, 0, 3'd5);

      // R1 threshold 4 during a frame, R10 no fall while idle
      for (int i = 0; i < 4; i++) step(1, 8'(8'h20 + i), 0, 1, 0, 3'd4);
      for (int i = 0; i < 3; i++) begin
         step(0, 8'h00, 0, 1, 0, 3'd4);
         chk("R10", "ready held", int'(ready), 1);
      end
      // fill up, then R5 overflow with a marker byte
      step(1, 8'h24, 0, 1, 0, 3'd4);
      step(1, 8'h25, 0, 1, 0, 3'd4);
      step(1, 8'hEE, 0, 1, 0, 3'd4);
      step(1, 8'hEF, 1, 1, 0, 3'd4);
      // R8 read and write together in the middle
      step(1, 8'h30, 1, 1, 0, 3'd4);
      step(1, 8'h31, 1, 1, 0, 3'd4);
      // drain, R3 with thresh 0
      for (int i = 0; i < 7; i++) step(0, 8'h00, 1, 1, 0, 3'd0);
      step(1, 8'h40, 0, 1, 0, 3'd0);
      step(0, 8'h00, 0, 1, 0, 3'd0);
      // threshold above depth is never reached
      step(0, 8'h00, 0, 1, 0, 3'd7);
      // R6/R7 flush of a non-empty FIFO with a write in the same cycle
      step(1, 8'h41, 0, 1, 0, 3'd2);
      step(1, 8'h55, 1, 1, 1, 3'd2);
      step(0, 8'h00, 1, 1, 0, 3'd2);
      // R7 flush of an empty FIFO, no write
      step(0, 8'h00, 0, 1, 1, 3'd2);
      // flush of a full FIFO
      for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h60 + i), 0, 1, 0, 3'd3);
      step(0, 8'h00, 0, 0, 1, 3'd3);

      // constrained random traffic
      begin
         bit            fa = 1'b1;
         logic [CW-1:0] th = 3'd3;
         for (int n = 0; n < 4000; n++) begin
            if (($urandom % 64) == 0) fa = !fa;
            if (($urandom % 32) == 0) th = CW'($urandom % 8);
            step(($urandom % 100) < 55, 8'($urandom), ($urandom % 100) < 45,
                 fa, ($urandom % 80) == 0, th);
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule